// File: doc/BRIEF.md
# Two-Beat Token Hash Sequencer

This block lets a requester ask for the digest of a wide token from a hashing engine that runs on a different clock. The requester holds the token steady and raises a request. The request crosses into the engine clock domain through a two-flop synchronizer. There a small state machine sends the token to the engine as two beats on a valid/ready stream: first the low half, then the high half. It then waits for the engine's completion flag and stores the digest and error bit that come with it.

Once the result is stored, the engine side raises an acknowledge toward the requester. The requester side synchronizes that acknowledge and captures the stored digest and error bit. It keeps its acknowledge high until the requester drops the request. The forwarded request is masked by the requester's own acknowledge, so a request that is still high is not issued again.

Each clock domain has its own asynchronous active-low reset. After completion the engine-side machine parks in its done state. Only the engine-domain reset can take it out of that state, so any later request gets the same stored result again without new beats. After dropping a request, the requester waits for the acknowledge to settle before raising a new one.

Top module: `token_hash_seq`

## Requirements
- R1: After reset, and while no request is pending, `beat_valid_o` stays low. `tok_ack_o` stays low.
- R2: The first beat carries `tok_i[TOK_W/2-1:0]`, with `beat_last_o`=0 and `beat_strb_o`=0. While `beat_ready_i` is low, the beat stays valid and unchanged.
- R3: The second beat carries `tok_i[TOK_W-1:TOK_W/2]`, with `beat_last_o`=1 and every bit of `beat_strb_o` set. While `beat_ready_i` is low, the beat stays valid and unchanged.
- R4: After the second beat is accepted, no beat is valid and no acknowledge appears until `eng_done_i` is sampled high. The `eng_digest_i` and `eng_err_i` values sampled at that edge become the result.
- R5: When a request is answered, `tok_ack_o` rises with `digest_o` and `err_o` equal to the stored result. All three hold while `tok_req_i` stays high. `tok_ack_o` falls one requester clock after `tok_req_i` falls.
- R6: Once the done state is reached, a later request is answered with the same stored result and no further beats, until the engine-domain reset.
- R7: `rst_eng_n` returns the engine side to the first-beat state from any state. A later request then sends two fresh beats and returns the new result.
- R8: `rst_req_n` low clears `tok_ack_o`, `digest_o` and `err_o`.
- R9: The requester holds `tok_i` stable while `tok_req_i` is high and `tok_ack_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_req | input | 1 | Requester-domain clock |
| rst_req_n | input | 1 | Requester-domain asynchronous active-low reset |
| tok_req_i | input | 1 | Hash request |
| tok_i | input | TOK_W | Token to hash |
| tok_ack_o | output | 1 | Result acknowledge |
| digest_o | output | DIG_W | Returned digest |
| err_o | output | 1 | Returned error flag |
| clk_eng | input | 1 | Engine-domain clock |
| rst_eng_n | input | 1 | Engine-domain asynchronous active-low reset |
| beat_valid_o | output | 1 | Beat valid |
| beat_data_o | output | TOK_W/2 | Beat payload |
| beat_last_o | output | 1 | Final beat marker |
| beat_strb_o | output | TOK_W/16 | Byte strobes, set on the final beat |
| beat_ready_i | input | 1 | Engine accepts the beat |
| eng_done_i | input | 1 | Engine completion flag |
| eng_digest_i | input | DIG_W | Engine digest, sampled with the completion flag |
| eng_err_i | input | 1 | Engine error, sampled with the completion flag |

## Verification
Two events can land in the same engine clock cycle: the first beat becoming valid and the engine accepting it. This happens when ready is already high as the synchronized request arrives. Runs with ready tied high provoke this case, and the recorded beats must show both halves in order with no repeat. A second collision is a requester reset that lands while the acknowledge is high and the request is still asserted. The bench forces this and expects the acknowledge and result cleared at once, ahead of any new capture.

// File: rtl/token_hash_pkg.sv
package token_hash_pkg;

    typedef enum logic [1:0] {
        SEQ_LO   = 2'b00,
        SEQ_HI   = 2'b01,
        SEQ_WAIT = 2'b10,
        SEQ_DONE = 2'b11
    } seq_state_e;

endpackage

// File: rtl/th_sync.sv
module th_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/th_eng_seq.sv
module th_eng_seq
    import token_hash_pkg::*;
#(
    parameter int TOK_W = 128,
    parameter int DIG_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_s,
    input  logic [TOK_W-1:0]       tok_i,
    output logic                   beat_valid_o,
    output logic [TOK_W/2-1:0]     beat_data_o,
    output logic                   beat_last_o,
    output logic [TOK_W/16-1:0]    beat_strb_o,
    input  logic                   beat_ready_i,
    input  logic                   done_i,
    input  logic [DIG_W-1:0]       dig_i,
    input  logic                   err_i,
    output logic                   ack_o,
    output logic [DIG_W-1:0]       dig_o,
    output logic                   err_o
);
    localparam int BEAT_W = TOK_W / 2;
    localparam int STRB_W = BEAT_W / 8;

    typedef struct packed {
        seq_state_e       st;
        logic             ack;
        logic [DIG_W-1:0] dig;
        logic             err;
    } eng_reg_t;

    eng_reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d        = cur_q;
        beat_valid_o = 1'b0;
        beat_data_o  = tok_i[BEAT_W-1:0];
        beat_last_o  = 1'b0;
        beat_strb_o  = '0;
        case (cur_q.st)
            SEQ_LO: begin
                if (req_s) begin
                    beat_valid_o = 1'b1;
                    if (beat_ready_i) nxt_d.st = SEQ_HI;
                end
            end
            SEQ_HI: begin
                beat_valid_o = 1'b1;
                beat_data_o  = tok_i[TOK_W-1:BEAT_W];
                beat_last_o  = 1'b1;
                beat_strb_o  = {STRB_W{1'b1}};
                if (beat_ready_i) nxt_d.st = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (done_i) begin
                    nxt_d.st  = SEQ_DONE;
                    nxt_d.dig = dig_i;
                    nxt_d.err = err_i;
                end
            end
            SEQ_DONE: begin
                nxt_d.st = SEQ_DONE;
            end
            default: begin
                nxt_d.st     = SEQ_LO;
                beat_valid_o = 1'b0;
                beat_last_o  = 1'b0;
                beat_strb_o  = '0;
            end
        endcase
        nxt_d.ack = (cur_q.st == SEQ_DONE) && req_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: SEQ_LO, ack: 1'b0, dig: '0, err: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign ack_o = cur_q.ack;
    assign dig_o = cur_q.dig;
    assign err_o = cur_q.err;
endmodule

// File: rtl/th_req_side.sv
module th_req_side #(
    parameter int DIG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             ack_s,
    input  logic [DIG_W-1:0] eng_dig_i,
    input  logic             eng_err_i,
    output logic             req_x_o,
    output logic             ack_o,
    output logic [DIG_W-1:0] dig_o,
    output logic             err_o
);
    typedef struct packed {
        logic             ack;
        logic [DIG_W-1:0] dig;
        logic             err;
    } req_reg_t;

    req_reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.ack = req_i & (cur_q.ack | ack_s);
        if (req_i && ack_s && !cur_q.ack) begin
            nxt_d.dig = eng_dig_i;
            nxt_d.err = eng_err_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{ack: 1'b0, dig: '0, err: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign req_x_o = req_i & ~cur_q.ack;
    assign ack_o   = cur_q.ack;
    assign dig_o   = cur_q.dig;
    assign err_o   = cur_q.err;
endmodule

// File: rtl/token_hash_seq.sv
module token_hash_seq #(
    parameter int TOK_W       = 128,
    parameter int DIG_W       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_req,
    input  logic                rst_req_n,
    input  logic                tok_req_i,
    input  logic [TOK_W-1:0]    tok_i,
    output logic                tok_ack_o,
    output logic [DIG_W-1:0]    digest_o,
    output logic                err_o,
    input  logic                clk_eng,
    input  logic                rst_eng_n,
    output logic                beat_valid_o,
    output logic [TOK_W/2-1:0]  beat_data_o,
    output logic                beat_last_o,
    output logic [TOK_W/16-1:0] beat_strb_o,
    input  logic                beat_ready_i,
    input  logic                eng_done_i,
    input  logic [DIG_W-1:0]    eng_digest_i,
    input  logic                eng_err_i
);
    logic             req_x, req_s;
    logic             eng_ack, ack_s;
    logic [DIG_W-1:0] eng_dig;
    logic             eng_err;

    th_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk_eng), .rst_n(rst_eng_n), .d(req_x), .q(req_s)
    );

    th_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk_req), .rst_n(rst_req_n), .d(eng_ack), .q(ack_s)
    );

    th_eng_seq #(.TOK_W(TOK_W), .DIG_W(DIG_W)) u_eng (
        .clk(clk_eng), .rst_n(rst_eng_n), .req_s(req_s), .tok_i(tok_i),
        .beat_valid_o(beat_valid_o), .beat_data_o(beat_data_o),
        .beat_last_o(beat_last_o), .beat_strb_o(beat_strb_o),
        .beat_ready_i(beat_ready_i), .done_i(eng_done_i),
        .dig_i(eng_digest_i), .err_i(eng_err_i),
        .ack_o(eng_ack), .dig_o(eng_dig), .err_o(eng_err)
    );

    th_req_side #(.DIG_W(DIG_W)) u_req (
        .clk(clk_req), .rst_n(rst_req_n), .req_i(tok_req_i), .ack_s(ack_s),
        .eng_dig_i(eng_dig), .eng_err_i(eng_err), .req_x_o(req_x),
        .ack_o(tok_ack_o), .dig_o(digest_o), .err_o(err_o)
    );
endmodule

// File: rtl/token_hash_seq_chk.sv
module token_hash_seq_chk #(
    parameter int TOK_W = 128,
    parameter int DIG_W = 64
) (
    input logic                clk_req,
    input logic                rst_req_n,
    input logic                tok_req_i,
    input logic [TOK_W-1:0]    tok_i,
    input logic                tok_ack_o,
    input logic [DIG_W-1:0]    digest_o,
    input logic                err_o,
    input logic                clk_eng,
    input logic                rst_eng_n,
    input logic                beat_valid_o,
    input logic [TOK_W/2-1:0]  beat_data_o,
    input logic                beat_last_o,
    input logic [TOK_W/16-1:0] beat_strb_o,
    input logic                beat_ready_i
);
    // R2 R3
    beat_hold_chk: assert property (@(posedge clk_eng) disable iff (!rst_eng_n)
        beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_data_o) && $stable(beat_last_o));

    // R3
    strb_last_chk: assert property (@(posedge clk_eng) disable iff (!rst_eng_n)
        beat_valid_o |-> (beat_last_o ? (&beat_strb_o) : (beat_strb_o == '0)));

    // R5
    ack_keep_chk: assert property (@(posedge clk_req) disable iff (!rst_req_n)
        tok_ack_o && tok_req_i |=> tok_ack_o && $stable(digest_o) && $stable(err_o));

    // R5
    ack_fall_chk: assert property (@(posedge clk_req) disable iff (!rst_req_n)
        !tok_req_i |=> !tok_ack_o);

    // R8
    req_reset_chk: assert property (@(posedge clk_req)
        !rst_req_n |=> !tok_ack_o && (digest_o == '0) && !err_o);

    // R9
    tok_stable_chk: assert property (@(posedge clk_req) disable iff (!rst_req_n)
        tok_req_i && !tok_ack_o |=> !tok_req_i || $stable(tok_i));
endmodule

bind token_hash_seq token_hash_seq_chk #(.TOK_W(TOK_W), .DIG_W(DIG_W)) u_chk (
    .clk_req(clk_req), .rst_req_n(rst_req_n), .tok_req_i(tok_req_i), .tok_i(tok_i),
    .tok_ack_o(tok_ack_o), .digest_o(digest_o), .err_o(err_o),
    .clk_eng(clk_eng), .rst_eng_n(rst_eng_n), .beat_valid_o(beat_valid_o),
    .beat_data_o(beat_data_o), .beat_last_o(beat_last_o),
    .beat_strb_o(beat_strb_o), .beat_ready_i(beat_ready_i)
);

// File: tb/token_hash_seq_test.sv
module token_hash_seq_test;
    localparam int TOK_W = 128;
    localparam int DIG_W = 64;

    logic clk_req = 1'b0, clk_eng = 1'b0;
    logic rst_req_n = 1'b0, rst_eng_n = 1'b0;
    logic tok_req = 1'b0;
    logic [TOK_W-1:0] tok = '0;
    logic tok_ack, err;
    logic [DIG_W-1:0] digest;
    logic bvalid, blast, bready = 1'b0, edone = 1'b0, eerr = 1'b0;
    logic [TOK_W/2-1:0] bdata;
    logic [TOK_W/16-1:0] bstrb;
    logic [DIG_W-1:0] edig = '0;

    int total = 0, bad = 0;
    int beat_n = 0, valid_n = 0, dly = 0;
    bit force0 = 0, shot = 0, hold_done = 0, pend = 0, fast = 0;

    always #5 clk_req = ~clk_req;
    always #7 clk_eng = ~clk_eng;

    token_hash_seq #(.TOK_W(TOK_W), .DIG_W(DIG_W)) uut (
        .clk_req(clk_req), .rst_req_n(rst_req_n), .tok_req_i(tok_req), .tok_i(tok),
        .tok_ack_o(tok_ack), .digest_o(digest), .err_o(err),
        .clk_eng(clk_eng), .rst_eng_n(rst_eng_n), .beat_valid_o(bvalid),
        .beat_data_o(bdata), .beat_last_o(blast), .beat_strb_o(bstrb),
        .beat_ready_i(bready), .eng_done_i(edone), .eng_digest_i(edig), .eng_err_i(eerr)
    );

    function automatic logic [DIG_W-1:0] hash_of(input logic [TOK_W-1:0] t);
        return t[63:0] ^ {t[114:64], t[127:115]} ^ 64'h5a5a_3c3c_0f0f_9696;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [TOK_W-1:0] act,
                       input logic [TOK_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // engine responder model
    initial begin
        forever begin
            @(negedge clk_eng);
            if (shot) begin bready = 1'b1; shot = 0; end
            else if (force0) bready = 1'b0;
            else bready = fast ? 1'b1 : 1'($urandom % 2);
            if (edone) edone = 1'b0;
            else if (pend && !hold_done) begin
                if (dly == 0) begin
                    edone = 1'b1; edig = hash_of(tok); eerr = ^tok; pend = 0;
                end else dly--;
            end
            #1;
            if (bvalid) valid_n++;
            if (bvalid && bready) begin
                if (beat_n == 0) begin
                    chk(bdata == tok[63:0] && !blast && bstrb == '0, "R2 first beat",
                        {blast, bstrb, bdata}, {1'b0, 8'h00, tok[63:0]});
                end else if (beat_n == 1) begin
                    chk(bdata == tok[127:64] && blast && bstrb == 8'hFF, "R3 second beat",
                        {blast, bstrb, bdata}, {1'b1, 8'hFF, tok[127:64]});
                    pend = 1; dly = int'($urandom % 6);
                end else begin
                    chk(1'b0, "R6 extra beat after done", beat_n, 2);
                end
                beat_n++;
            end
        end
    end

    task automatic eng_reset();
        @(negedge clk_eng);
        rst_eng_n = 1'b0; pend = 0; edone = 1'b0;
        repeat (3) @(negedge clk_eng);
        beat_n = 0;
        rst_eng_n = 1'b1;
        repeat (4) @(negedge clk_req);
    endtask

    task automatic wait_ack(output bit seen);
        seen = 0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk_req);
            if (tok_ack) seen = 1;
        end
    endtask

    task automatic run_txn(input logic [TOK_W-1:0] t, input logic [DIG_W-1:0] exp_d,
                           input bit exp_e, input int exp_beats, input string tag);
        bit seen;
        @(negedge clk_req);
        tok = t; tok_req = 1'b1;
        wait_ack(seen);
        chk(seen, {tag, " ack rises"}, seen, 1);
        chk(digest == exp_d && err == exp_e, {tag, " result"}, {err, digest}, {exp_e, exp_d});
        chk(beat_n == exp_beats, {tag, " beat count"}, beat_n, exp_beats);
        repeat (5) @(negedge clk_req);
        chk(tok_ack && digest == exp_d, "R5 ack and digest held", {tok_ack, digest}, {1'b1, exp_d});
        tok_req = 1'b0;
        @(negedge clk_req);
        chk(!tok_ack, "R5 ack falls after request drops", tok_ack, 0);
        repeat (12) @(negedge clk_req);
    endtask

    initial begin
        repeat (150000) @(posedge clk_req);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [TOK_W-1:0] t, t2, tsv;
        bit seen;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk_req);
        chk(!tok_ack && digest == '0 && !err, "R8 reset state", {tok_ack, err, digest}, 0);
        chk(!bvalid, "R1 reset valid low", bvalid, 0);
        rst_req_n = 1'b1; rst_eng_n = 1'b1;
        repeat (30) @(negedge clk_eng);
        chk(valid_n == 0 && !tok_ack, "R1 idle no beat", valid_n, 0);

        // directed stall: first beat, second beat, wait state
        force0 = 1; hold_done = 1;
        tsv = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
        @(negedge clk_req); tok = tsv; tok_req = 1'b1;
        repeat (20) @(negedge clk_eng); #2;
        chk(bvalid && bdata == tsv[63:0] && !blast && bstrb == 0, "R2 stalled first beat",
            {bvalid, blast, bdata}, {1'b1, 1'b0, tsv[63:0]});
        shot = 1;
        repeat (10) @(negedge clk_eng); #2;
        chk(bvalid && bdata == tsv[127:64] && blast && bstrb == 8'hFF, "R3 stalled second beat",
            {bvalid, blast, bstrb, bdata}, {1'b1, 1'b1, 8'hFF, tsv[127:64]});
        force0 = 0;
        repeat (20) @(negedge clk_eng); #2;
        chk(!bvalid && !tok_ack && beat_n == 2, "R4 waiting for done", {bvalid, tok_ack, beat_n}, 2);
        hold_done = 0;
        wait_ack(seen);
        chk(seen && digest == hash_of(tsv) && err == ^tsv, "R4 result from done",
            {err, digest}, {^tsv, hash_of(tsv)});
        tok_req = 1'b0;
        repeat (12) @(negedge clk_req);

        // terminal done state: fresh token gets old result
        t2 = ~tsv;
        run_txn(t2, hash_of(tsv), ^tsv, 2, "R6 repeat in done");

        // requester reset while acknowledge high, request asserted
        @(negedge clk_req); tok = t2; tok_req = 1'b1;
        wait_ack(seen);
        chk(seen, "R6 ack before reset", seen, 1);
        rst_req_n = 1'b0; #1;
        chk(!tok_ack && digest == '0 && !err, "R8 requester reset clears", {tok_ack, err, digest}, 0);
        @(negedge clk_req); tok_req = 1'b0;
        @(negedge clk_req); rst_req_n = 1'b1;
        repeat (12) @(negedge clk_req);

        // random transactions, each after an engine reset
        for (int i = 0; i < 16; i++) begin
            fast = (i % 3 == 0);
            eng_reset();
            t = {$urandom, $urandom, $urandom, $urandom};
            run_txn(t, hash_of(t), ^t, 2, "R7 after engine reset");
            if (i % 4 == 1) begin
                t2 = {$urandom, $urandom, $urandom, $urandom};
                run_txn(t2, hash_of(t), ^t, 2, "R6 done is terminal");
            end
        end
        fast = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule